// File: doc/BRIEF.md
# Ternary Priority Match Table

This block is a small ternary match table. Each row stores an 80-bit value, an 80-bit care mask and a valid flag. A care bit of 1 means the stored value bit must equal the key bit. A care bit of 0 marks the position as don't-care, in the same way a netmask hides the host part of an address. A write port loads one row at a given index. A search port presents an 80-bit key, which is compared against every row at once. The result is a hit flag and the index of the winning row.

When several rows match, the row with the lowest index wins. Software that loads longer prefixes at lower indices therefore gets longest-prefix-match routing. A row with every care bit cleared acts as a default route: it matches any key and is only reached when no more specific row matches. Every search takes the same time, whatever the row count and whatever the rows contain.

Searches run through a two-stage pipeline. Stage one registers the per-row match vector. Stage two registers the encoded winner. A small state machine tracks which stages are occupied:

- `PL_EMPTY`: no stage is occupied.
- `PL_FILL`: only stage one holds a search.
- `PL_DRAIN`: only stage two holds a result.
- `PL_FULL`: both stages are occupied.

On every edge, the next state is formed from two things: whether a search strobe is present, and whether stage one is currently occupied. The transitions are:

- A strobe moves `PL_EMPTY` or `PL_DRAIN` to `PL_FILL`, and moves `PL_FILL` or `PL_FULL` to `PL_FULL`.
- With no strobe, `PL_FILL` or `PL_FULL` moves to `PL_DRAIN`, and `PL_EMPTY` or `PL_DRAIN` moves to `PL_EMPTY`.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every row is invalid, `res_vld` is 0, and a search returns `res_hit`=0 with `res_idx`=0.
- R2: A valid row matches a key when, at every position whose care bit is 1, the stored bit equals the key bit. Positions whose care bit is 0 match either key value.
- R3: A row whose valid flag is 0 never matches. Writing a row with `wr_valid`=0 removes it from later searches.
- R4: A search strobed in the cycle ending at clock edge E raises `res_vld` for exactly one cycle, after edge E+1. Searches may be strobed on consecutive cycles, and each produces its own result in order.
- R5: When several rows match, `res_idx` is the lowest matching index (index 0 has the highest priority).
- R6: When no row matches, the result carries `res_hit`=0 and `res_idx`=0. While `res_vld` is 0, both `res_hit` and `res_idx` are 0.
- R7: When a write and a search occur in the same cycle, the search sees the table contents from before the write. The write affects only later searches.
- R8: With prefixes loaded longest-first (/20 at index 0, /13 at 1, /8 at 2, /0 at 3, in key bits 31:0 with bits 79:32 don't-care), key 0x1D5EDC86 returns index 0.
- R9: A valid row with every care bit 0 matches any key and serves as the fallback when no lower-indexed row matches.
- R10: A write replaces the value, mask and valid flag of the addressed row. A later search reflects only the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one row this cycle |
| wr_idx | input | IDX_W (4) | Row index to load |
| wr_value | input | KEY_W (80) | Stored value bits |
| wr_care | input | KEY_W (80) | Care mask, 1 = compare, 0 = don't-care |
| wr_valid | input | 1 | Valid flag stored with the row |
| srch_vld | input | 1 | Search strobe |
| srch_key | input | KEY_W (80) | Search key |
| res_vld | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | At least one valid row matched |
| res_idx | output | IDX_W (4) | Lowest matching row index, 0 on a miss |

## Verification
Every search result is due on the second clock edge after its strobe is sampled. The bench drives inputs on the falling edge and reads the outputs on the three falling edges that follow the strobe: it expects `res_vld` low, then high with the result, then low again. Back-to-back searches are checked one result per falling edge, starting two falling edges after the first strobe. A write issued together with a search is checked on the same schedule, so the result shows whether the old table contents were used. Random masks and keys are compared against a linear-scan model that finds the first matching valid row.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [1:0] {
        PL_EMPTY = 2'b00,
        PL_FILL  = 2'b01,
        PL_DRAIN = 2'b10,
        PL_FULL  = 2'b11
    } pipe_state_t;

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
    parameter int KEY_W = 80,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_care,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] key,
    output logic [DEPTH-1:0] hit_vec
);

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_row
            logic [KEY_W-1:0] val_q;
            logic [KEY_W-1:0] care_q;
            logic             vld_q;
            logic             sel;

            assign sel = wr_en && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q  <= '0;
                    care_q <= '0;
                    vld_q  <= 1'b0;
                end else if (sel) begin
                    val_q  <= wr_value;
                    care_q <= wr_care;
                    vld_q  <= wr_valid;
                end
            end

            // Row compare: only positions with care set must agree.
            always_comb begin
                hit_vec[g] = vld_q && (((key ^ val_q) & care_q) == '0);
            end
        end
    endgenerate

    // R3: a row written invalid is silent on the next search.
    p_cleared_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !hit_vec[$past(wr_idx)]);

    // R9: a valid all-don't-care row matches whatever key follows.
    p_default_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid && (wr_care == '0)) |=> hit_vec[$past(wr_idx)]);

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] win
);

    logic [DEPTH-1:0] below;

    always_comb begin
        any = |req;
        win = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = i[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            below[i] = (i < int'(win));
        end
    end

    // R5: the winner is a requesting row and nothing below it requests.
    always_comb begin
        a_lowest_wins_r5: assert (!any || (req[win] && ((req & below) == '0)));
    end

endmodule

// File: rtl/tcam_pipe_ctrl.sv
module tcam_pipe_ctrl
    import tcam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srch_vld,
    output logic cap_en,
    output logic enc_en,
    output logic res_vld
);

    pipe_state_t state_q;
    pipe_state_t state_d;

    always_comb begin
        unique case (state_q)
            PL_EMPTY, PL_DRAIN: state_d = srch_vld ? PL_FILL : PL_EMPTY;
            PL_FILL,  PL_FULL:  state_d = srch_vld ? PL_FULL : PL_DRAIN;
            default:            state_d = PL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cap_en = srch_vld;
        unique case (state_q)
            PL_EMPTY: begin enc_en = 1'b0; res_vld = 1'b0; end
            PL_FILL:  begin enc_en = 1'b1; res_vld = 1'b0; end
            PL_DRAIN: begin enc_en = 1'b0; res_vld = 1'b1; end
            PL_FULL:  begin enc_en = 1'b1; res_vld = 1'b1; end
            default:  begin enc_en = 1'b0; res_vld = 1'b0; end
        endcase
    end

    // R4: a filled stage one always yields a result pulse next cycle.
    p_fill_reports_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enc_en |=> res_vld);

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
    parameter int KEY_W = 80,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_care,
    input  logic             wr_valid,
    input  logic             srch_vld,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_vld,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx
);

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] match_q;
    logic             cap_en;
    logic             enc_en;
    logic             enc_any;
    logic [IDX_W-1:0] enc_win;
    logic             hit_q;
    logic [IDX_W-1:0] idx_q;

    tcam_store #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_value (wr_value),
        .wr_care  (wr_care),
        .wr_valid (wr_valid),
        .key      (srch_key),
        .hit_vec  (hit_vec)
    );

    tcam_pipe_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_vld (srch_vld),
        .cap_en   (cap_en),
        .enc_en   (enc_en),
        .res_vld  (res_vld)
    );

    // Stage one: the compare uses the contents before any same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (cap_en) begin
            match_q <= hit_vec;
        end
    end

    tcam_prio_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_enc (
        .req (match_q),
        .any (enc_any),
        .win (enc_win)
    );

    // Stage two: the result registers are zero whenever no result is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (enc_en) begin
            hit_q <= enc_any;
            idx_q <= enc_any ? enc_win : '0;
        end else begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end
    end

    assign res_hit = hit_q;
    assign res_idx = idx_q;

    // R4: every strobe is answered two edges later.
    p_two_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        srch_vld |-> ##2 res_vld);

    // R6: result fields are quiet outside the result pulse.
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (!res_hit && (res_idx == '0)));

    // R6: a miss reports index zero.
    p_miss_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_idx == '0));

endmodule

// File: tb/test_tcam_lookup.sv
module test_tcam_lookup;

    localparam int KW = 80;
    localparam int DP = 16;
    localparam int IW = 4;
    localparam int NV = 7;

    // LPM vectors: key, expected {hit, idx}
    localparam logic [KW-1:0] VKEY [NV] = '{
        {48'h0, 32'h1D5EDC86},
        {48'h0, 32'h1D000001},
        {48'h0, 32'h2C312345},
        {48'h0, 32'h2C380000},
        {48'h0, 32'h1D5EC000},
        {48'h0, 32'hAABBCCDD},
        {48'hFFFF_1234_5678, 32'h1D5EDC86}
    };
    localparam logic [IW:0] VEXP [NV] = '{
        5'h10, 5'h12, 5'h11, 5'h13, 5'h12, 5'h13, 5'h10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_care = '0;
    logic          wr_valid = 1'b0;
    logic          srch_vld = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          res_vld;
    logic          res_hit;
    logic [IW-1:0] res_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [KW-1:0] m_val  [DP];
    logic [KW-1:0] m_care [DP];
    logic          m_vld  [DP];

    always #10 clk = ~clk;

    tcam_lookup i_tcam_lookup (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
        .srch_vld(srch_vld), .srch_key(srch_key),
        .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [KW-1:0] rnd80();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic write_row(input int idx, input logic [KW-1:0] v, input logic [KW-1:0] c, input logic vl);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_value = v; wr_care = c; wr_valid = vl;
        @(negedge clk);
        wr_en = 1'b0;
        m_val[idx] = v; m_care[idx] = c; m_vld[idx] = vl;
    endtask

    function automatic logic [IW:0] model(input logic [KW-1:0] k);
        for (int i = 0; i < DP; i++) begin
            if (m_vld[i] && (((k ^ m_val[i]) & m_care[i]) == '0)) return {1'b1, IW'(i)};
        end
        return '0;
    endfunction

    // Strobe at one negedge; expect quiet, pulse, quiet on the next three.
    task automatic search(input logic [KW-1:0] k, input logic [IW:0] exp, input string req);
        logic v1, v2, v3;
        logic [IW:0] got;
        @(negedge clk);
        srch_vld = 1'b1; srch_key = k;
        @(negedge clk);
        srch_vld = 1'b0;
        v1 = res_vld;
        check(!res_hit && res_idx == '0, "R6 idle fields", {res_hit, res_idx}, 0);
        @(negedge clk);
        v2 = res_vld; got = {res_hit, res_idx};
        @(negedge clk);
        v3 = res_vld;
        check(!v1 && v2 && !v3, "R4 pulse timing", {v1, v2, v3}, 3'b010);
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DP; i++) begin m_val[i] = '0; m_care[i] = '0; m_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check(res_vld == 1'b0 && res_hit == 1'b0 && res_idx == '0, "R1 reset outputs", {res_vld, res_hit, res_idx}, 0);
        rst_n = 1'b1;
        // R1: empty table misses
        search({48'h0, 32'h1D5EDC86}, 5'h00, "R1 empty table miss");
        search('1, 5'h00, "R1 empty table miss all-ones");

        // R8 / R9: longest-first prefixes and default row
        write_row(0, {48'h0, 32'h1D5ED000}, {48'h0, 32'hFFFFF000}, 1'b1);
        write_row(1, {48'h0, 32'h2C300000}, {48'h0, 32'hFFF80000}, 1'b1);
        write_row(2, {48'h0, 32'h1D000000}, {48'h0, 32'hFF000000}, 1'b1);
        write_row(3, '0, '0, 1'b1);
        for (int v = 0; v < NV; v++) begin
            search(VKEY[v], VEXP[v], "R8 R9 R2 R5 prefix vector");
        end

        // R3 / R6: removing the default row turns an unmatched key into a miss
        write_row(3, '0, '0, 1'b0);
        search({48'h0, 32'hAABBCCDD}, 5'h00, "R3 R6 invalid default miss");

        // R7: write together with search sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd5; wr_value = {48'h0, 32'hAABBCCDD}; wr_care = '1; wr_valid = 1'b1;
        srch_vld = 1'b1; srch_key = {48'h0, 32'hAABBCCDD};
        @(negedge clk);
        wr_en = 1'b0; srch_vld = 1'b0;
        m_val[5] = {48'h0, 32'hAABBCCDD}; m_care[5] = '1; m_vld[5] = 1'b1;
        @(negedge clk);
        check(res_vld && {res_hit, res_idx} == 5'h00, "R7 same-cycle write unseen", {res_vld, res_hit, res_idx}, 6'h20);
        search({48'h0, 32'hAABBCCDD}, 5'h15, "R7 write seen later");

        // R10: overwrite row 5 with a different value
        write_row(5, {48'h0, 32'h11223344}, '1, 1'b1);
        search({48'h0, 32'hAABBCCDD}, 5'h00, "R10 old value gone");
        search({48'h0, 32'h11223344}, 5'h15, "R10 new value found");

        // R4: back-to-back searches, one result per cycle in order
        @(negedge clk); srch_vld = 1'b1; srch_key = {48'h0, 32'h1D5EDC86};
        @(negedge clk); srch_key = {48'h0, 32'h2C312345};
        @(negedge clk); srch_key = {48'h0, 32'h11223344};
        check(res_vld && {res_hit, res_idx} == 5'h10, "R4 back-to-back first", {res_vld, res_hit, res_idx}, 6'h30);
        @(negedge clk); srch_vld = 1'b0;
        check(res_vld && {res_hit, res_idx} == 5'h11, "R4 back-to-back second", {res_vld, res_hit, res_idx}, 6'h31);
        @(negedge clk);
        check(res_vld && {res_hit, res_idx} == 5'h15, "R4 back-to-back third", {res_vld, res_hit, res_idx}, 6'h35);
        @(negedge clk);
        check(!res_vld && !res_hit && res_idx == '0, "R4 R6 pulse ends", {res_vld, res_hit, res_idx}, 0);

        // R2 / R5 / R3: random masks against the linear-scan model
        for (int i = 0; i < DP; i++) begin
            logic [KW-1:0] c;
            c = rnd80() | rnd80();
            write_row(i, rnd80(), c, ($urandom() % 4) != 0);
        end
        for (int t = 0; t < 300; t++) begin
            logic [KW-1:0] k;
            int e;
            e = int'($urandom() % DP);
            if ((t % 4) == 3) k = rnd80();
            else k = (m_val[e] & m_care[e]) | (rnd80() & ~m_care[e]);
            if ((t % 37) == 0) write_row(e, rnd80(), rnd80() & rnd80(), ($urandom() % 3) != 0);
            search(k, model(k), "R2 R3 R5 random vs model");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule